// File: doc/BRIEF.md
# Three-Product Complex Multiplier

This block forms the product of two complex operands, x = x_re + j·x_im and y = y_re + j·y_im. Each of the four parts is a signed two's-complement word entered as-is, with the sign carried in the top bit. Internally only three real multiplications are performed. The product y_re·(x_re − x_im) is evaluated once and feeds both result paths:

- real part: (y_re − y_im)·x_im + y_re·(x_re − x_im)
- imaginary part: (y_re + y_im)·x_re − y_re·(x_re − x_im)

Those two lines reduce algebraically to the direct form.

A caller presents the four parts together with `in_valid`. One clock later, the full-precision results appear at `z_re` and `z_im` with `out_valid` high. The result registers keep their contents while no new operand is offered, so a consumer can read them at leisure. Nothing is rounded, saturated or scaled. The pre-sums are one bit wider than the inputs, and the products and results are wide enough that every input combination is represented exactly.

Top module: `cmul3_top`

## Requirements
- R1: One cycle after a cycle with `in_valid` high, `z_re` equals x_re·y_re − x_im·y_im of the operands presented in that cycle, as a 35-bit signed value (for the default 16-bit parts).
- R2: One cycle after a cycle with `in_valid` high, `z_im` equals x_re·y_im + x_im·y_re of those operands, as a 35-bit signed value.
- R3: Results are exact for all inputs, including operands at the most negative value −32768 and the most positive value 32767; no wrap-around occurs.
- R4: `out_valid` is high in exactly the cycle after a cycle in which `in_valid` was high, and low otherwise.
- R5: While `in_valid` is low, `z_re` and `z_im` keep their previous values whatever the operand inputs do.
- R6: When `rst_n` is low at a rising clock edge, `out_valid`, `z_re` and `z_im` become 0 after that edge, even if `in_valid` is high.
- R7: A new operand set is accepted on every cycle; back-to-back valid inputs give back-to-back results in the same order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand strobe: the four parts are taken this cycle |
| x_re | input | 16 | Real part of first operand, signed |
| x_im | input | 16 | Imaginary part of first operand, signed |
| y_re | input | 16 | Real part of second operand, signed |
| y_im | input | 16 | Imaginary part of second operand, signed |
| out_valid | output | 1 | High in the cycle a new result is presented |
| z_re | output | 35 | Real part of the product, signed |
| z_im | output | 35 | Imaginary part of the product, signed |

## Verification
The hardest condition to reach from the ports is a reset that lands in the same cycle as a valid operand set. In that case the clear must win over the load, and the scoreboard must not expect the lost result. The stimulus raises `in_valid` with live operands while pulling `rst_n` low for two edges, and pushes no expectation for that beat. The stimulus also fills every idle gap with fresh random operands, so that any leakage into the held results shows up as a mismatch. Extreme-value corners (all parts at −32768, mixed maximum and minimum) exercise the widest pre-sums and products.

// File: rtl/cmul3_pkg.sv
// Shared constants for the three-product complex multiplier.
// Assumes: part width is chosen at the top; these are defaults only.
package cmul3_pkg;
    localparam int CMUL_PART_W = 16;  // default width of one real/imag part
    localparam int CMUL_NMUL   = 3;   // number of real multipliers in the datapath
    localparam int CMUL_M_SHARED = 1; // index of the shared product y_re*(x_re-x_im)
endpackage

// File: rtl/cmul3_preadd.sv
// Pre-adder stage: forms the three operand sums feeding the multipliers.
// Assumes: inputs are signed two's complement of width W; outputs are W+1
// bits, so no sum or difference can overflow.
module cmul3_preadd #(
    parameter int W = 16,
    localparam int PW = W + 1
) (
    input  logic signed [W-1:0]  a_in,   // x_re
    input  logic signed [W-1:0]  b_in,   // x_im
    input  logic signed [W-1:0]  c_in,   // y_re
    input  logic signed [W-1:0]  d_in,   // y_im
    output logic signed [PW-1:0] amb,    // x_re - x_im
    output logic signed [PW-1:0] cmd,    // y_re - y_im
    output logic signed [PW-1:0] cpd,    // y_re + y_im
    output logic signed [PW-1:0] a_ext,  // x_re widened
    output logic signed [PW-1:0] b_ext,  // x_im widened
    output logic signed [PW-1:0] c_ext   // y_re widened
);
    // Widen every part by one sign bit, then form the sums.
    always_comb begin
        a_ext = $signed({a_in[W-1], a_in});
        b_ext = $signed({b_in[W-1], b_in});
        c_ext = $signed({c_in[W-1], c_in});
        amb   = a_ext - b_ext;
        cmd   = c_ext - $signed({d_in[W-1], d_in});
        cpd   = c_ext + $signed({d_in[W-1], d_in});
    end
endmodule

// File: rtl/cmul3_smul.sv
// One signed real multiplier producing a full-width product.
// Assumes: both operands are signed; the product width AW+BW is exact.
module cmul3_smul #(
    parameter int AW = 17,
    parameter int BW = 17,
    localparam int RW = AW + BW
) (
    input  logic signed [AW-1:0] op_a,
    input  logic signed [BW-1:0] op_b,
    output logic signed [RW-1:0] prod
);
    // Full-precision signed product.
    always_comb prod = op_a * op_b;
endmodule

// File: rtl/cmul3_postadd.sv
// Post-adder stage: combines the three products into real and imaginary
// results. The shared product enters both paths with opposite signs.
// Assumes: products are PRW bits signed; results are PRW+1 bits signed.
module cmul3_postadd #(
    parameter int PRW = 34,
    localparam int OW = PRW + 1
) (
    input  logic signed [PRW-1:0] p_re_only,  // (y_re - y_im) * x_im
    input  logic signed [PRW-1:0] p_shared,   // y_re * (x_re - x_im)
    input  logic signed [PRW-1:0] p_im_only,  // (y_re + y_im) * x_re
    output logic signed [OW-1:0]  sum_re,
    output logic signed [OW-1:0]  sum_im
);
    logic signed [OW-1:0] w_re_only, w_shared, w_im_only;

    // Sign-extend the products and form both results.
    always_comb begin
        w_re_only = $signed({p_re_only[PRW-1], p_re_only});
        w_shared  = $signed({p_shared[PRW-1],  p_shared});
        w_im_only = $signed({p_im_only[PRW-1], p_im_only});
        sum_re    = w_re_only + w_shared;
        sum_im    = w_im_only - w_shared;
    end
endmodule

// File: rtl/cmul3_top.sv
// Complex multiplier with three real products and one register stage.
// Assumes: parts are signed W-bit words; the result is registered when
// in_valid is high and held otherwise; reset is synchronous, active low.
module cmul3_top
    import cmul3_pkg::*;
#(
    parameter int W = CMUL_PART_W,
    localparam int PW  = W + 1,
    localparam int PRW = 2 * PW,
    localparam int OW  = PRW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [W-1:0]  x_re,
    input  logic [W-1:0]  x_im,
    input  logic [W-1:0]  y_re,
    input  logic [W-1:0]  y_im,
    output logic          out_valid,
    output logic [OW-1:0] z_re,
    output logic [OW-1:0] z_im
);
    logic signed [PW-1:0]  amb, cmd, cpd, a_ext, b_ext, c_ext;
    logic signed [PW-1:0]  mul_l [CMUL_NMUL];
    logic signed [PW-1:0]  mul_r [CMUL_NMUL];
    logic signed [PRW-1:0] mul_p [CMUL_NMUL];
    logic signed [OW-1:0]  sum_re, sum_im;

    cmul3_preadd #(.W(W)) u_pre (
        .a_in (x_re), .b_in (x_im), .c_in (y_re), .d_in (y_im),
        .amb  (amb),  .cmd  (cmd),  .cpd  (cpd),
        .a_ext(a_ext), .b_ext(b_ext), .c_ext(c_ext)
    );

    // Route operand pairs to the multipliers: 0 real-only, 1 shared, 2 imag-only.
    always_comb begin
        mul_l[0] = cmd;            mul_r[0] = b_ext;
        mul_l[CMUL_M_SHARED] = c_ext; mul_r[CMUL_M_SHARED] = amb;
        mul_l[2] = cpd;            mul_r[2] = a_ext;
    end

    for (genvar k = 0; k < CMUL_NMUL; k++) begin : g_mul
        cmul3_smul #(.AW(PW), .BW(PW)) u_mul (
            .op_a(mul_l[k]), .op_b(mul_r[k]), .prod(mul_p[k])
        );
    end

    cmul3_postadd #(.PRW(PRW)) u_post (
        .p_re_only(mul_p[0]), .p_shared(mul_p[CMUL_M_SHARED]), .p_im_only(mul_p[2]),
        .sum_re(sum_re), .sum_im(sum_im)
    );

    // Output register: clear on reset, load on a valid strobe, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            z_re      <= '0;
            z_im      <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                z_re <= sum_re;
                z_im <= sum_im;
            end
        end
    end

    // Direct four-product reference, used by the assertions only.
    logic signed [OW-1:0] dir_re, dir_im, xr_w, xi_w, yr_w, yi_w;
    always_comb begin
        xr_w   = $signed({{(OW-W){x_re[W-1]}}, x_re});
        xi_w   = $signed({{(OW-W){x_im[W-1]}}, x_im});
        yr_w   = $signed({{(OW-W){y_re[W-1]}}, y_re});
        yi_w   = $signed({{(OW-W){y_im[W-1]}}, y_im});
        dir_re = xr_w * yr_w - xi_w * yi_w;
        dir_im = xr_w * yi_w + xi_w * yr_w;
    end

    p_real_r1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ($signed(z_re) == $past(dir_re)));
    p_imag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ($signed(z_im) == $past(dir_im)));
    p_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(z_re) && $stable(z_im)));
    p_clear_r6: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && z_re == '0 && z_im == '0));
endmodule

// File: tb/test_cmul3_top.sv
// Scoreboard bench: the driver queues expected results, the monitor compares.
module test_cmul3_top;
    localparam int W  = 16;
    localparam int OW = 2 * (W + 1) + 1;

    typedef struct { longint re; longint im; } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [W-1:0] x_re = '0, x_im = '0, y_re = '0, y_im = '0;
    logic out_valid;
    logic [OW-1:0] z_re, z_im;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    exp_t exp_q[$];
    logic exp_valid = 1'b0;
    bit rst_seen = 1'b0;
    longint last_re = 0, last_im = 0;

    cmul3_top #(.W(W)) i_cmul3_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .x_re(x_re), .x_im(x_im), .y_re(y_re), .y_im(y_im),
        .out_valid(out_valid), .z_re(z_re), .z_im(z_im)
    );

    always #2 clk = ~clk;

    // Bench model of the valid pipeline (R4) and of reset having been seen.
    always @(posedge clk) begin
        exp_valid <= rst_n ? in_valid : 1'b0;
        rst_seen  <= !rst_n;
    end

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Monitor: sample at the falling edge, compare against the scoreboard.
    always @(negedge clk) begin
        if (rst_seen) begin
            check(out_valid == 1'b0, "R6 valid", longint'(out_valid), 0);
            check($signed(z_re) == 0 && $signed(z_im) == 0, "R6 data",
                  longint'($signed(z_re)), 0);
            last_re = 0; last_im = 0;
        end else if (rst_n) begin
            check(out_valid == exp_valid, "R4", longint'(out_valid), longint'(exp_valid));
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 unexpected result", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(longint'($signed(z_re)) == e.re, "R1/R3/R7 real",
                          longint'($signed(z_re)), e.re);
                    check(longint'($signed(z_im)) == e.im, "R2/R3/R7 imag",
                          longint'($signed(z_im)), e.im);
                end
                last_re = longint'($signed(z_re));
                last_im = longint'($signed(z_im));
            end else begin
                check(longint'($signed(z_re)) == last_re && longint'($signed(z_im)) == last_im,
                      "R5 hold", longint'($signed(z_re)), last_re);
            end
        end
    end

    // Driver: present one operand set and queue its expected product.
    task automatic send(input int a, input int b, input int c, input int d);
        exp_t e;
        @(posedge clk); #1;
        x_re = W'(a); x_im = W'(b); y_re = W'(c); y_im = W'(d);
        in_valid = 1'b1;
        e.re = longint'(a) * c - longint'(b) * d;
        e.im = longint'(a) * d + longint'(b) * c;
        exp_q.push_back(e);
    endtask

    // Idle cycles with churning operands that must be ignored (R5).
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            in_valid = 1'b0;
            x_re = W'($urandom); x_im = W'($urandom);
            y_re = W'($urandom); y_im = W'($urandom);
        end
    endtask

    function automatic int rnd16();
        return int'($signed(16'($urandom)));
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1/R2 basic patterns
        send(3, 2, 5, -4);
        send(1, 2, 3, 0);    // real second operand
        send(1, 2, 0, 3);    // imaginary second operand
        send(0, 0, 0, 0);
        idle(3);             // R5 hold with random operands
        // R3 extremes
        send(-32768, -32768, -32768, -32768);
        send(32767, -32768, -32768, 32767);
        send(32767, 32767, 32767, 32767);
        send(-32768, 32767, 32767, -32768);
        send(-1, -1, -1, -1);
        idle(2);
        // R7 back-to-back random stream
        for (int i = 0; i < 200; i++) send(rnd16(), rnd16(), rnd16(), rnd16());
        idle(4);
        // R6 reset while a valid operand is offered: no expectation queued
        @(posedge clk); #1;
        rst_n = 1'b0; in_valid = 1'b1;
        x_re = 16'h1234; x_im = 16'h0F0F; y_re = 16'h7FFF; y_im = 16'h8000;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1; in_valid = 1'b0;
        idle(3);
        for (int i = 0; i < 50; i++) begin
            send(rnd16(), rnd16(), rnd16(), rnd16());
            if (i % 7 == 0) idle(1);
        end
        idle(4);
        check(exp_q.size() == 0, "R7 drained", longint'(exp_q.size()), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule